// File: doc/BRIEF.md
# Dual Constituent Turbo Encoder

This block turns one frame of information bits into soft symbols using two parallel recursive systematic convolutional encoders. The first encoder sees the bits in their natural order. The second sees the same frame reordered by an interleaver. The block does not compute the permutation. For every information stage it presents the stage number on `il_stage`, and the environment returns, in the same cycle, the frame position that the second encoder must read. The whole frame is first loaded bit by bit into an internal store, so that it can later be read in any order.

After the last information stage, the first encoder is flushed for three stages and then the second encoder is flushed for three stages. In each flush stage the register input is taken from the feedback path, which drives the encoder back to state zero. Each output beat carries up to five two-bit soft symbols on fixed lanes, and a lane-enable mask shows which lanes are in use for the selected code rate. Input, output and frame start all use valid/ready style handshakes. A last flag marks the final flush beat.

Top module: `turbo_enc_dual`

## Requirements
- R1: While reset is held and after it is released, `in_ready`, `out_valid` and `out_last` are low until a frame is started.
- R2: A `start` pulse is accepted only when the block is idle and `frame_len` lies in 40..5114; at that point `frame_len` and `rate_sel` are captured (rate_sel 1 = rate 1/5, 0 = rate 1/3). A start with any other length, or a start that arrives while a frame is in progress, has no effect.
- R3: After an accepted start, `in_ready` stays high until exactly `frame_len` bits have been taken (`in_valid` and `in_ready` high at a clock edge), with bit k of the frame being the k-th bit taken. Then `in_ready` drops and `out_valid` rises.
- R4: Each encoder has three delay cells, cleared at every accepted start. With cells s1 (newest), s2 and s3, the feedback is f = s2^s3 and the cell input is w = u^f. The parity outputs are A = w^s1^s3 and B = w^s1^s2^s3, and the systematic output is X = u.
- R5: During information stage k, `il_stage` equals k. The second encoder's input u is frame bit number `il_pos`, and its outputs are A' and B'.
- R6: Information beats put X on lane 0, A on lane 1, B on lane 2, A' on lane 3 and B' on lane 4. `out_lane_en` is 5'b11111 at rate 1/5 and 5'b01011 at rate 1/3.
- R7: Lane i occupies `out_sym[2i+1:2i]`. An enabled lane carries 2'b01 (+1) for logic 1 and 2'b11 (-1) for logic 0. A disabled lane carries 2'b00.
- R8: After the information beats come three flush beats of the first encoder and then three flush beats of the second. In a flush stage u = f, so w = 0 and X = f. First-encoder flush beats use lanes 0,1,2 (mask 5'b00111, or 5'b00011 at rate 1/3) for X, A, B. Second-encoder flush beats use lanes 0,3,4 (mask 5'b11001, or 5'b01001 at rate 1/3) for X', A', B'. Both encoders end in state zero.
- R9: A frame gives exactly `frame_len`+6 output beats, and `out_last` is high only on the final one.
- R10: A beat advances only when `out_valid` and `out_ready` are both high. While it is held, `out_sym`, `out_lane_en` and `out_last` stay stable.
- R11: After the last beat is taken, the block is idle again and accepts a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Frame start request |
| frame_len | input | 13 | Information bits in the frame |
| rate_sel | input | 1 | 1 = rate 1/5, 0 = rate 1/3 |
| in_valid | input | 1 | Information bit offered |
| in_bit | input | 1 | Information bit value |
| in_ready | output | 1 | Frame store accepts a bit |
| il_stage | output | 13 | Current stage number for the permutation lookup |
| il_pos | input | 13 | Frame position to read for the second encoder |
| out_valid | output | 1 | Symbol beat available |
| out_ready | input | 1 | Consumer takes the beat |
| out_sym | output | 10 | Five two-bit soft symbols, lane i at bits 2i+1:2i |
| out_lane_en | output | 5 | Lanes in use on this beat |
| out_last | output | 1 | Final flush beat of the frame |

## Verification
An all-zero frame with the identity permutation must produce -1 on every enabled lane. This separates sign mapping and lane masking from the encoder arithmetic. Random frames with random permutations are compared beat by beat against an independent model of both encoders. These frames expose wrong taps, wrong lane placement, and a second encoder that reads the natural index instead of `il_pos`. The shortest and longest lengths, as well as lengths just outside the range, test where the frame starts and where it ends. Random gaps on `in_valid` and `out_ready`, together with stray start pulses during a frame, show whether the block holds its outputs and ignores requests it should not take.

// File: rtl/te_pkg.sv
package te_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_LOAD  = 3'd1,
    PH_INFO  = 3'd2,
    PH_TAIL1 = 3'd3,
    PH_TAIL2 = 3'd4
  } phase_t;

  localparam int unsigned LANES = 5;
  localparam int unsigned SYM_W = 2;

  // Soft symbol: +1 for logic 1, -1 for logic 0, zero for an idle lane.
  function automatic logic [SYM_W-1:0] to_sym(input logic b, input logic en);
    logic [SYM_W-1:0] s;
    if (!en)    s = 2'b00;
    else if (b) s = 2'b01;
    else        s = 2'b11;
    return s;
  endfunction

endpackage

// File: rtl/te_bit_store.sv
module te_bit_store #(
  parameter int unsigned MAX_LEN = 5114,
  parameter int unsigned LEN_W   = 13,
  parameter int unsigned WORD_W  = 16
) (
  input  logic             clk,
  input  logic             we,
  input  logic [LEN_W-1:0] waddr,
  input  logic             wbit,
  input  logic [LEN_W-1:0] raddr_a,
  output logic             rbit_a,
  input  logic [LEN_W-1:0] raddr_b,
  output logic             rbit_b
);

  localparam int unsigned DEPTH = (MAX_LEN + WORD_W - 1) / WORD_W;
  localparam int unsigned COL_W = $clog2(WORD_W);
  localparam int unsigned ROW_W = $clog2(DEPTH);

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr[COL_W +: ROW_W]][waddr[COL_W-1:0]] <= wbit;
    end
  end

  assign rbit_a = mem[raddr_a[COL_W +: ROW_W]][raddr_a[COL_W-1:0]];
  assign rbit_b = mem[raddr_b[COL_W +: ROW_W]][raddr_b[COL_W-1:0]];

endmodule

// File: rtl/te_rsc.sv
module te_rsc #(
  parameter int unsigned    MEM     = 3,
  parameter logic [MEM-1:0] FB_TAPS = 3'b110,
  parameter logic [MEM-1:0] A_TAPS  = 3'b101,
  parameter logic [MEM-1:0] B_TAPS  = 3'b111
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear,
  input  logic           advance,
  input  logic           tail,
  input  logic           u,
  output logic           x,
  output logic           a,
  output logic           b,
  output logic [MEM-1:0] state
);

  // state[0] holds the newest delay cell, state[MEM-1] the oldest.
  logic [MEM-1:0] st_q, st_d;
  logic           fb, w;

  always_comb begin
    fb   = ^(st_q & FB_TAPS);
    w    = tail ? 1'b0 : (u ^ fb);
    x    = tail ? fb : u;
    a    = w ^ (^(st_q & A_TAPS));
    b    = w ^ (^(st_q & B_TAPS));
    st_d = {st_q[MEM-2:0], w};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
    end else if (clear) begin
      st_q <= '0;
    end else if (advance) begin
      st_q <= st_d;
    end
  end

  assign state = st_q;

  // R8
  tail_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && tail && !clear) |=> (st_q[0] == 1'b0));

endmodule

// File: rtl/te_ctrl.sv
module te_ctrl
  import te_pkg::*;
#(
  parameter int unsigned MIN_LEN  = 40,
  parameter int unsigned MAX_LEN  = 5114,
  parameter int unsigned LEN_W    = 13,
  parameter int unsigned TAIL_LEN = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] frame_len,
  input  logic             rate_sel,
  input  logic             in_valid,
  input  logic             out_ready,
  output phase_t           phase,
  output logic [LEN_W-1:0] cnt,
  output logic             rate,
  output logic             in_ready,
  output logic             out_valid,
  output logic             out_last,
  output logic             load_fire,
  output logic             out_fire,
  output logic             clear
);

  phase_t           phase_q, phase_d;
  logic [LEN_W-1:0] cnt_q, cnt_d, len_q, len_d;
  logic             rate_q, rate_d;
  logic             len_ok, start_acc, end_len, end_tail, reg_en;

  always_comb begin
    len_ok    = (frame_len >= LEN_W'(MIN_LEN)) && (frame_len <= LEN_W'(MAX_LEN));
    start_acc = (phase_q == PH_IDLE) && start && len_ok;
    in_ready  = (phase_q == PH_LOAD);
    out_valid = (phase_q == PH_INFO) || (phase_q == PH_TAIL1) || (phase_q == PH_TAIL2);
    load_fire = in_ready && in_valid;
    out_fire  = out_valid && out_ready;
    end_len   = (cnt_q == len_q - LEN_W'(1));
    end_tail  = (cnt_q == LEN_W'(TAIL_LEN - 1));
    out_last  = (phase_q == PH_TAIL2) && end_tail;
    reg_en    = start_acc || load_fire || out_fire;
  end

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    len_d   = len_q;
    rate_d  = rate_q;
    case (phase_q)
      PH_IDLE: begin
        if (start_acc) begin
          phase_d = PH_LOAD;
          cnt_d   = '0;
          len_d   = frame_len;
          rate_d  = rate_sel;
        end
      end
      PH_LOAD: begin
        if (load_fire) begin
          if (end_len) begin
            phase_d = PH_INFO;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + LEN_W'(1);
          end
        end
      end
      PH_INFO: begin
        if (out_fire) begin
          if (end_len) begin
            phase_d = PH_TAIL1;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + LEN_W'(1);
          end
        end
      end
      PH_TAIL1: begin
        if (out_fire) begin
          if (end_tail) begin
            phase_d = PH_TAIL2;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + LEN_W'(1);
          end
        end
      end
      PH_TAIL2: begin
        if (out_fire) begin
          if (end_tail) begin
            phase_d = PH_IDLE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + LEN_W'(1);
          end
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      len_q   <= '0;
      rate_q  <= 1'b0;
    end else if (reg_en) begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      len_q   <= len_d;
      rate_q  <= rate_d;
    end
  end

  assign phase = phase_q;
  assign cnt   = cnt_q;
  assign rate  = rate_q;
  assign clear = start_acc;

  // R3
  load_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (cnt_q < len_q));

  // R2
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE && start) |=> ($stable(len_q) && $stable(rate_q)));

  // R10
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(cnt_q) && $stable(phase_q)));

  // R9
  last_in_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> (out_valid && phase_q == PH_TAIL2));

endmodule

// File: rtl/turbo_enc_dual.sv
module turbo_enc_dual
  import te_pkg::*;
#(
  parameter int unsigned MIN_LEN  = 40,
  parameter int unsigned MAX_LEN  = 5114,
  parameter int unsigned LEN_W    = 13,
  parameter int unsigned WORD_W   = 16,
  parameter int unsigned MEM      = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [LEN_W-1:0]       frame_len,
  input  logic                   rate_sel,
  input  logic                   in_valid,
  input  logic                   in_bit,
  output logic                   in_ready,
  output logic [LEN_W-1:0]       il_stage,
  input  logic [LEN_W-1:0]       il_pos,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [LANES*SYM_W-1:0] out_sym,
  output logic [LANES-1:0]       out_lane_en,
  output logic                   out_last
);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  phase_t           phase;
  logic [LEN_W-1:0] cnt;
  logic             rate, load_fire, out_fire, clear;
  logic             u1, u2;
  logic             x1, a1, b1, x2, a2, b2;
  logic [MEM-1:0]   st1, st2;
  logic             adv1, adv2, tail1, tail2;
  logic [LANES-1:0] lane_bit;

  te_ctrl #(
    .MIN_LEN (MIN_LEN),
    .MAX_LEN (MAX_LEN),
    .LEN_W   (LEN_W),
    .TAIL_LEN(MEM)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .start    (start),
    .frame_len(frame_len),
    .rate_sel (rate_sel),
    .in_valid (in_valid),
    .out_ready(out_ready),
    .phase    (phase),
    .cnt      (cnt),
    .rate     (rate),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_last (out_last),
    .load_fire(load_fire),
    .out_fire (out_fire),
    .clear    (clear)
  );

  te_bit_store #(
    .MAX_LEN(MAX_LEN),
    .LEN_W  (LEN_W),
    .WORD_W (WORD_W)
  ) u_store (
    .clk    (clk),
    .we     (load_fire),
    .waddr  (cnt),
    .wbit   (in_bit),
    .raddr_a(cnt),
    .rbit_a (u1),
    .raddr_b(il_pos),
    .rbit_b (u2)
  );

  assign tail1 = (phase == PH_TAIL1);
  assign tail2 = (phase == PH_TAIL2);
  assign adv1  = out_fire && ((phase == PH_INFO) || tail1);
  assign adv2  = out_fire && ((phase == PH_INFO) || tail2);

  te_rsc #(.MEM(MEM)) u_enc_nat (
    .clk(clk), .rst_n(rst_i_n), .clear(clear), .advance(adv1), .tail(tail1),
    .u(u1), .x(x1), .a(a1), .b(b1), .state(st1)
  );

  te_rsc #(.MEM(MEM)) u_enc_ilv (
    .clk(clk), .rst_n(rst_i_n), .clear(clear), .advance(adv2), .tail(tail2),
    .u(u2), .x(x2), .a(a2), .b(b2), .state(st2)
  );

  always_comb begin
    lane_bit    = '0;
    out_lane_en = '0;
    case (phase)
      PH_INFO: begin
        lane_bit    = {b2, a2, b1, a1, x1};
        out_lane_en = rate ? 5'b11111 : 5'b01011;
      end
      PH_TAIL1: begin
        lane_bit    = {1'b0, 1'b0, b1, a1, x1};
        out_lane_en = rate ? 5'b00111 : 5'b00011;
      end
      PH_TAIL2: begin
        lane_bit    = {b2, a2, 1'b0, 1'b0, x2};
        out_lane_en = rate ? 5'b11001 : 5'b01001;
      end
      default: ;
    endcase
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign out_sym[i*SYM_W +: SYM_W] = to_sym(lane_bit[i], out_lane_en[i]);
  end

  assign il_stage = cnt;

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (out_valid && !out_ready) |=> ($stable(out_sym) && $stable(out_lane_en) && $stable(out_last)));

  // R8
  flush_zero_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (out_fire && out_last) |=> (st1 == '0 && st2 == '0));

  // R11
  idle_after_last_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (out_fire && out_last) |=> (!out_valid && !in_ready));

  // R6
  info_lane_count_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (out_valid && phase == PH_INFO) |-> ($countones(out_lane_en) == (rate ? 5 : 3)));

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(rst_i_n) |-> (!in_ready && !out_valid && !out_last));

endmodule

// File: tb/turbo_enc_dual_test.sv
`timescale 1ns/1ps
module turbo_enc_dual_test;

  logic        clk = 1'b0;
  logic        rst_n, start, rate_sel, in_valid, in_bit, out_ready;
  logic [12:0] frame_len, il_pos;
  logic        in_ready, out_valid, out_last;
  logic [12:0] il_stage;
  logic [9:0]  out_sym;
  logic [4:0]  out_lane_en;

  int checks = 0;
  int fails  = 0;

  logic        frame_bits [8192];
  logic [12:0] perm       [8192];

  always #10 clk = ~clk;

  assign il_pos = perm[il_stage];

  turbo_enc_dual uut (
    .clk(clk), .rst_n(rst_n), .start(start), .frame_len(frame_len),
    .rate_sel(rate_sel), .in_valid(in_valid), .in_bit(in_bit),
    .in_ready(in_ready), .il_stage(il_stage), .il_pos(il_pos),
    .out_valid(out_valid), .out_ready(out_ready), .out_sym(out_sym),
    .out_lane_en(out_lane_en), .out_last(out_last)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Model of one encoder step: returns {next_state[2:0], x, a, b}.
  function automatic logic [5:0] rsc_step(input logic [2:0] st, input logic u, input logic tl);
    logic f, w, x, a, b;
    f = st[1] ^ st[2];
    w = tl ? 1'b0 : (u ^ f);
    x = tl ? f : u;
    a = w ^ st[0] ^ st[2];
    b = w ^ st[0] ^ st[1] ^ st[2];
    return {st[1], st[0], w, x, a, b};
  endfunction

  function automatic logic [1:0] sym(input logic b, input logic en);
    return !en ? 2'b00 : (b ? 2'b01 : 2'b11);
  endfunction

  task automatic bad_start(input int len);
    @(negedge clk);
    frame_len = 13'(len);
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!in_ready && !out_valid, "R2", "out-of-range start ignored",
          {30'd0, in_ready, out_valid}, 32'd0);
    end
  endtask

  task automatic run_frame(input int len, input bit rate, input bit ident,
                           input bit zeros, input bit poke);
    int          k;
    int          beat;
    int          total;
    bit          r;
    logic [2:0]  st1, st2;
    logic [5:0]  r1, r2;
    logic [4:0]  en, lb;
    logic [9:0]  exp_sym;
    string       tag;

    for (int i = 0; i < len; i++) begin
      frame_bits[i] = zeros ? 1'b0 : 1'($urandom % 2);
      perm[i]       = 13'(i);
    end
    if (!ident) begin
      for (int i = len - 1; i > 0; i--) begin
        int j;
        logic [12:0] t;
        j = int'($urandom % (i + 1));
        t = perm[i]; perm[i] = perm[j]; perm[j] = t;
      end
    end

    @(negedge clk);
    frame_len = 13'(len);
    rate_sel  = rate;
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(in_ready == 1'b1, "R2", "valid start accepted", {31'd0, in_ready}, 32'd1);

    k = 0;
    while (k < len) begin
      bit v;
      @(negedge clk);
      start = (poke && k == len / 2);
      frame_len = start ? 13'd40 : 13'(len);
      v = ($urandom % 4) != 0;
      in_valid = v;
      in_bit   = frame_bits[k];
      if (v && in_ready) k++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    start    = 1'b0;
    chk(!in_ready && out_valid, "R3", "load ends after frame_len bits",
        {30'd0, in_ready, out_valid}, 32'd1);

    st1 = '0;
    st2 = '0;
    beat  = 0;
    total = len + 6;
    r1 = '0;
    r2 = '0;
    while (beat < total) begin
      @(negedge clk);
      start = (poke && beat == 2);
      if (!out_valid) begin
        chk(1'b0, "R9", "out_valid dropped early", 32'(beat), 32'(total));
        break;
      end
      if (beat < len) begin
        r1  = rsc_step(st1, frame_bits[beat], 1'b0);
        r2  = rsc_step(st2, frame_bits[perm[beat]], 1'b0);
        en  = rate ? 5'b11111 : 5'b01011;
        lb  = {r2[0], r2[1], r1[0], r1[1], r1[2]};
        tag = "R4,R5,R6,R7";
      end else if (beat < len + 3) begin
        r1  = rsc_step(st1, 1'b0, 1'b1);
        en  = rate ? 5'b00111 : 5'b00011;
        lb  = {2'b00, r1[0], r1[1], r1[2]};
        tag = "R8,R7";
      end else begin
        r2  = rsc_step(st2, 1'b0, 1'b1);
        en  = rate ? 5'b11001 : 5'b01001;
        lb  = {r2[0], r2[1], 2'b00, r2[2]};
        tag = "R8,R7";
      end
      for (int i = 0; i < 5; i++) exp_sym[2*i +: 2] = sym(lb[i], en[i]);
      chk(out_sym == exp_sym, tag, "out_sym", 32'(out_sym), 32'(exp_sym));
      chk(out_lane_en == en, tag, "out_lane_en", 32'(out_lane_en), 32'(en));
      chk(out_last == (beat == total - 1), "R9", "out_last",
          32'(out_last), 32'(beat == total - 1));
      r = ($urandom % 3) != 0;
      out_ready = r;
      if (r) begin
        if (beat < len + 3) st1 = r1[5:3];
        if (beat < len || beat >= len + 3) st2 = r2[5:3];
        beat++;
      end
    end
    @(negedge clk);
    out_ready = 1'b0;
    start     = 1'b0;
    chk(!out_valid && !in_ready, "R11", "idle after last beat",
        {30'd0, out_valid, in_ready}, 32'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog run did not complete actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7011));
    rst_n = 1'b0; start = 1'b0; frame_len = '0; rate_sel = 1'b0;
    in_valid = 1'b0; in_bit = 1'b0; out_ready = 1'b0;
    for (int i = 0; i < 8192; i++) perm[i] = '0;
    repeat (3) @(negedge clk);
    chk(!in_ready && !out_valid && !out_last, "R1", "outputs in reset",
        {29'd0, in_ready, out_valid, out_last}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!in_ready && !out_valid && !out_last, "R1", "outputs after reset",
        {29'd0, in_ready, out_valid, out_last}, 32'd0);

    bad_start(39);
    bad_start(5115);
    bad_start(0);

    run_frame(40, 1'b1, 1'b1, 1'b1, 1'b0);
    run_frame(40, 1'b0, 1'b1, 1'b1, 1'b0);
    run_frame(40, 1'b1, 1'b0, 1'b0, 1'b1);
    run_frame(41, 1'b0, 1'b0, 1'b0, 1'b0);
    for (int n = 0; n < 6; n++) begin
      run_frame(40 + int'($urandom % 400), 1'($urandom % 2), 1'b0, 1'b0, 1'($urandom % 2));
    end
    run_frame(5114, 1'b1, 1'b0, 1'b0, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule